// File: doc/BRIEF.md
# Scanline Overlay for Video Stream

This block sits in a pixel stream on its way to a framebuffer or a digital video encoder and gives the picture the look of a CRT by forcing whole rows to black. Each beat carries one pixel word made of three colour channels, plus a valid flag, a start-of-frame marker on the first pixel of a frame and an end-of-line marker on the last pixel of each row. The block tracks the row's position inside a repeating period and blacks out the last row of every period. The period is three rows for the standard display geometry and two rows for the modified geometry.

A board strap turns the effect on or off, and a mode input picks the geometry. Both are sampled only on the start-of-frame pixel, so one frame never mixes two settings. The output stream is the input stream delayed by one register, with the timing markers carried along unchanged.

Top module: `scanline_overlay`

## Requirements
- R1: After reset, out_valid, out_sof and out_eol are low and out_pixel is zero. Until the first valid start-of-frame pixel has been accepted, the effect is off and valid pixels pass unchanged.
- R2: In a frame whose start-of-frame pixel saw strap_en = 0, every valid pixel leaves the block unchanged.
- R3: In a frame that began with strap_en = 1 and mode_alt = 0 (standard geometry), every pixel of a row whose index mod 3 equals 2 is blacked out, and all other rows pass unchanged.
- R4: In a frame that began with strap_en = 1 and mode_alt = 1 (modified geometry), every pixel of a row whose index mod 2 equals 1 is blacked out, and all other rows pass unchanged.
- R5: A blacked-out pixel has all bits of all three channels at zero, whatever its input value. The effect never dims a pixel part of the way.
- R6: Row 0 starts at the pixel that carries valid and in_sof. The row index goes up by one after each pixel that carries valid and in_eol, and the pattern restarts at each period. A pixel that has both in_sof and in_eol is a one-pixel row 0.
- R7: strap_en and mode_alt are sampled only on a valid start-of-frame pixel. A change to either input during a frame has no effect until the next start of frame.
- R8: Every output (out_valid, out_sof, out_eol, out_pixel) follows the matching input with exactly one clock cycle of latency.
- R9: On a beat with in_valid low, the row index does not move (an in_eol on such a beat is ignored), and in_pixel is copied to out_pixel without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat carries a pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a row |
| in_pixel | input | 3*CH_W | Pixel word with three colour channels |
| strap_en | input | 1 | Scanline effect enable from a board jumper |
| mode_alt | input | 1 | 0 = standard geometry (period 3), 1 = modified geometry (period 2) |
| out_valid | output | 1 | Delayed in_valid |
| out_sof | output | 1 | Delayed in_sof |
| out_eol | output | 1 | Delayed in_eol |
| out_pixel | output | 3*CH_W | Pixel word, black on striped rows |

## Verification
The bench runs whole frames with every combination of strap and geometry and predicts each output word from the row index, so a design with the wrong period or the wrong row phase puts the stripes on the wrong rows. Invalid beats that carry an end-of-line marker and junk data are placed between pixels. A design that lets such a marker advance the row shifts every later stripe, and one that blanks invalid data shows a zero where the copy was expected. Frames that flip the strap and the mode partway through catch a design that samples its settings live and stripes only part of the frame. Frames made of one-pixel rows, and all-ones pixels on blanked rows, check the case where start and end markers arrive on the same beat and confirm that blanking clears every bit of the word.

// File: rtl/scanline_pkg.sv
package scanline_pkg;

    typedef enum logic {
        GEOM_STD = 1'b0,
        GEOM_ALT = 1'b1
    } geom_e;

    typedef struct packed {
        logic  en;
        geom_e geom;
    } stripe_cfg_t;

    localparam stripe_cfg_t CFG_RESET = '{en: 1'b0, geom: GEOM_STD};

    function automatic int geom_period(geom_e g, int std_p, int alt_p);
        return (g == GEOM_ALT) ? alt_p : std_p;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/scanline_phase.sv
module scanline_phase
    import scanline_pkg::*;
#(
    parameter int STD_PERIOD = 3,
    parameter int ALT_PERIOD = 2,
    localparam int MAXP = max_of(STD_PERIOD, ALT_PERIOD),
    localparam int PW   = (MAXP > 2) ? $clog2(MAXP) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_eol,
    input  logic strap_en,
    input  logic mode_alt,
    output logic blank_req
);

    stripe_cfg_t cfg_q, cfg_cur;
    logic [PW-1:0] ph_q, ph_cur, ph_nxt, last_cur, last_q;
    logic frame_start;

    assign frame_start = in_valid && in_sof;

    always_comb begin
        if (frame_start) begin
            cfg_cur.en   = strap_en;
            cfg_cur.geom = mode_alt ? GEOM_ALT : GEOM_STD;
        end else begin
            cfg_cur = cfg_q;
        end
        last_cur = PW'(geom_period(cfg_cur.geom, STD_PERIOD, ALT_PERIOD) - 1);
        last_q   = PW'(geom_period(cfg_q.geom, STD_PERIOD, ALT_PERIOD) - 1);
        ph_cur   = frame_start ? '0 : ph_q;
        if (in_valid && in_eol)
            ph_nxt = (ph_cur == last_cur) ? '0 : ph_cur + 1'b1;
        else
            ph_nxt = ph_cur;
        blank_req = cfg_cur.en && (ph_cur == last_cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            ph_q  <= '0;
        end else begin
            cfg_q <= cfg_cur;
            ph_q  <= ph_nxt;
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        ph_q <= last_q); // R6

    AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(ph_q)); // R9

    AST_CFG_FRAME_LOCK: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/scanline_shade.sv
module scanline_shade #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    input  logic [PIX_W-1:0] in_pixel,
    input  logic             blank_req,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eol,
    output logic [PIX_W-1:0] out_pixel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
            out_pixel <= '0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_sof;
            out_eol   <= in_eol;
            out_pixel <= (in_valid && blank_req) ? '0 : in_pixel;
        end
    end

    AST_BLACK_FULL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && blank_req) |=> (out_pixel == '0)); // R5

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && blank_req) |=> (out_pixel == $past(in_pixel))); // R9

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8

    AST_IDLE_DELAY: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8

endmodule

// File: rtl/scanline_overlay.sv
module scanline_overlay #(
    parameter int CH_W       = 8,
    parameter int STD_PERIOD = 3,
    parameter int ALT_PERIOD = 2,
    localparam int PIX_W = 3 * CH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    input  logic [PIX_W-1:0] in_pixel,
    input  logic             strap_en,
    input  logic             mode_alt,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eol,
    output logic [PIX_W-1:0] out_pixel
);

    logic blank_req;

    scanline_phase #(
        .STD_PERIOD(STD_PERIOD),
        .ALT_PERIOD(ALT_PERIOD)
    ) phase_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .strap_en (strap_en),
        .mode_alt (mode_alt),
        .blank_req(blank_req)
    );

    scanline_shade #(
        .PIX_W(PIX_W)
    ) shade_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .in_pixel (in_pixel),
        .blank_req(blank_req),
        .out_valid(out_valid),
        .out_sof  (out_sof),
        .out_eol  (out_eol),
        .out_pixel(out_pixel)
    );

endmodule

// File: tb/scanline_overlay_tb.sv
module scanline_overlay_tb_top;

    localparam int PIX_W = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_sof = 1'b0;
    logic             in_eol = 1'b0;
    logic [PIX_W-1:0] in_pixel = '0;
    logic             strap_en = 1'b0;
    logic             mode_alt = 1'b0;
    logic             out_valid, out_sof, out_eol;
    logic [PIX_W-1:0] out_pixel;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scanline_overlay dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
        .in_pixel(in_pixel), .strap_en(strap_en), .mode_alt(mode_alt),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
        .out_pixel(out_pixel)
    );

    task automatic check(string tag, logic v, logic s, logic e, logic [PIX_W-1:0] p);
        vectors++;
        if (out_valid !== v || out_sof !== s || out_eol !== e || out_pixel !== p) begin
            miscompares++;
            $display("FAIL %s: got v=%b s=%b e=%b pix=%h, expected v=%b s=%b e=%b pix=%h",
                     tag, out_valid, out_sof, out_eol, out_pixel, v, s, e, p);
        end
    endtask

    // Drive one beat at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic beat(string tag, logic v, logic s, logic e, logic [PIX_W-1:0] p, bit blank);
        in_valid = v; in_sof = s; in_eol = e; in_pixel = p;
        @(posedge clk);
        @(negedge clk);
        check(tag, v, s, e, (v && blank) ? '0 : p);
    endtask

    // One frame; en/alt are applied before the start pixel, flip toggles both inputs after row 1.
    task automatic frame(bit en, bit alt, int rows, int cols, bit gaps, bit flip, bit ones, string tag);
        int per;
        per = alt ? 2 : 3;
        strap_en = en; mode_alt = alt;
        for (int r = 0; r < rows; r++) begin
            if (flip && r == 2) begin
                strap_en = ~en; mode_alt = ~alt;
            end
            for (int c = 0; c < cols; c++) begin
                logic [PIX_W-1:0] p;
                bit bl;
                p  = ones ? 24'hFFFFFF : PIX_W'((r * 16'h0135 + c * 8'h3B + 24'h102030) ^ (alt ? 24'h00FF00 : 24'h0));
                bl = en && ((r % per) == per - 1);
                beat(tag, 1'b1, (r == 0 && c == 0), (c == cols - 1), p, bl);
                if (gaps)
                    beat("R9", 1'b0, 1'b0, 1'b1, PIX_W'(24'hA5C3E1 ^ (r * 7 + c)), 1'b1);
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0, 1'b0, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 1'b0, 1'b0, '0);

        // R1: strap on but no frame start yet -> pass-through over several rows
        strap_en = 1'b1;
        for (int r = 0; r < 4; r++)
            beat("R1", 1'b1, 1'b0, 1'b1, PIX_W'(24'h0F0F0F + r), 1'b0);

        // R8: output does not move before the clock edge
        in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b1; in_pixel = 24'h123456;
        #1;
        check("R8", 1'b1, 1'b0, 1'b1, PIX_W'(24'h0F0F0F + 3));
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        @(negedge clk);
        check("R8", 1'b0, 1'b0, 1'b0, 24'h123456);

        // Sweep of strap and geometry
        for (int en = 0; en < 2; en++)
            for (int alt = 0; alt < 2; alt++)
                frame(en[0], alt[0], 9, 4, 1'b0, 1'b0, 1'b0,
                      (en == 0) ? "R2" : (alt == 0 ? "R3" : "R4"));

        frame(1'b1, 1'b0, 7, 3, 1'b1, 1'b0, 1'b0, "R3");
        frame(1'b1, 1'b1, 7, 3, 1'b1, 1'b0, 1'b0, "R4");
        frame(1'b1, 1'b0, 10, 1, 1'b0, 1'b0, 1'b0, "R6");
        frame(1'b1, 1'b1, 10, 1, 1'b1, 1'b0, 1'b0, "R6");
        frame(1'b1, 1'b0, 8, 3, 1'b0, 1'b1, 1'b0, "R7");
        frame(1'b1, 1'b1, 8, 3, 1'b0, 1'b1, 1'b0, "R7");
        frame(1'b0, 1'b0, 8, 3, 1'b0, 1'b1, 1'b0, "R7");
        frame(1'b1, 1'b0, 6, 2, 1'b0, 1'b0, 1'b1, "R5");
        frame(1'b1, 1'b1, 6, 2, 1'b0, 1'b0, 1'b1, "R5");
        frame(1'b0, 1'b1, 6, 2, 1'b0, 1'b0, 1'b1, "R2");

        beat("R9", 1'b0, 1'b0, 1'b0, 24'h000000, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule